// File: doc/BRIEF.md
# Opcode-Driven Accumulator Datapath

This block is an eight-bit datapath for a processor that is programmed from outside. One data bus feeds an opcode register, an accumulator A (through a two-way source select), and an operand register B. An ALU, a shifter behind it, a result register and a single carry flag complete the datapath. An external sequencer controls it through four load strobes, one each for the opcode, A, B and the result. A typical step is: latch an opcode, load the operands, latch a second opcode, then capture the result.

The opcode register's fields are wired straight to the A-source select, the ALU function, the shifter function and the carry-in select. No decoding is stored between them and the datapath. Because A can take the shifter output back, a list of numbers can be summed. Select the feedback source with an add opcode, then keep strobing A while new values arrive in B.

Every register runs on the one clock edge. Each has a synchronous load enable, and a synchronous reset clears them all. There are no internal states apart from the registers, so no sequencing lives inside the block.

Top module: `acc_datapath`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the opcode register, A, B, RES and the carry flag to 0.
- R2: Each of the opcode register, A, B and RES changes only at an edge where its own load strobe is high. Otherwise it holds its value.
- R3: With `ld_ir` high, the opcode register captures `data_in[7:0]`. Its fields are: bit 7 = A-source select, bits 6:4 = ALU function, bits 3:1 = shifter function, bit 0 = carry-in select.
- R4: When A loads, it takes `data_in` if opcode bit 7 is 0, and the shifter output if opcode bit 7 is 1.
- R5: The ALU function codes, where cin is the selected carry-in, are:
  - 000 = A+cin
  - 001 = B+cin
  - 010 = A+~B+cin
  - 011 = A+B+cin
  - 100 = A&B
  - 101 = A|B
  - 110 = A^B
  - 111 = all ones

  The arithmetic codes produce the adder carry-out. The other codes produce a carry-out of 0.
- R6: Opcode bit 0 = 0 gives a carry-in of 0. Opcode bit 0 = 1 uses the carry flag as the carry-in.
- R7: The shifter codes act on the ALU result y and carry k, and give an output and a carry-out:
  - 000 = pass y, carry-out k
  - 001 = shift left with 0 fill, carry-out y[7]
  - 010 = shift right with 0 fill, carry-out y[0]
  - 011 = rotate left through k, carry-out y[7]
  - 100 = rotate right through k, carry-out y[0]
  - 101 = rotate left, carry-out k
  - 110 = rotate right, carry-out k
  - 111 = arithmetic shift right, carry-out y[0]
- R8: Loading B clears the carry flag. Loading RES sets the carry flag to the shifter carry-out. When both strobes are high at the same edge, the carry-out wins.
- R9: When RES loads, it captures the shifter output.
- R10: All loads at one edge use the values held before that edge. An opcode loaded together with A does not steer that same A load. B loaded together with RES does not feed that same result.
- R11: With opcode 10110000 (feedback, add, pass, carry-in 0), repeated A loads accumulate the running sum modulo 256 of the successive B values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ld_ir | input | 1 | Load strobe for the opcode register |
| ld_a | input | 1 | Load strobe for A |
| ld_b | input | 1 | Load strobe for B; also clears the carry flag |
| ld_res | input | 1 | Load strobe for RES and the carry flag |
| data_in | input | 8 | Shared data bus |
| ir_q | output | 8 | Opcode register |
| a_q | output | 8 | A register |
| b_q | output | 8 | B register |
| res_q | output | 8 | Result register |
| carry_q | output | 1 | Carry flag |

## Verification
Two pairs of functions can fall in the same edge. The first pair is the opcode latch and the A load. The second pair is the B load, which clears the carry, and the result capture, which writes it. The bench strobes each pair together after setting up register contents whose old and new values give different results. It then checks that A followed the old opcode's source, and that RES used the old B. It also checks that the carry flag took the carry-out rather than the clear.

// File: rtl/acc_pkg.sv
package acc_pkg;

    localparam int OP_W = 8;

    typedef enum logic [2:0] {
        ALU_PASS_A = 3'b000,
        ALU_PASS_B = 3'b001,
        ALU_SUB    = 3'b010,
        ALU_ADD    = 3'b011,
        ALU_AND    = 3'b100,
        ALU_OR     = 3'b101,
        ALU_XOR    = 3'b110,
        ALU_ONES   = 3'b111
    } alu_fn_e;

    typedef enum logic [2:0] {
        SH_PASS = 3'b000,
        SH_SHL  = 3'b001,
        SH_SHR  = 3'b010,
        SH_RLC  = 3'b011,
        SH_RRC  = 3'b100,
        SH_ROL  = 3'b101,
        SH_ROR  = 3'b110,
        SH_ASR  = 3'b111
    } shift_fn_e;

    typedef struct packed {
        logic      a_from_shift;
        alu_fn_e   alu;
        shift_fn_e sh;
        logic      cin_from_c;
    } opcode_t;

endpackage

// File: rtl/acc_decode.sv
module acc_decode
    import acc_pkg::*;
(
    input  logic [OP_W-1:0] ir,
    output logic            a_from_shift,
    output alu_fn_e         alu_fn,
    output shift_fn_e       sh_fn,
    output logic            cin_from_c
);
    opcode_t fields;

    assign fields       = opcode_t'(ir);
    assign a_from_shift = fields.a_from_shift;
    assign alu_fn       = fields.alu;
    assign sh_fn        = fields.sh;
    assign cin_from_c   = fields.cin_from_c;
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  alu_fn_e      fn,
    output logic [W-1:0] y,
    output logic         cout
);
    logic [W-1:0] op_x, op_y, sum;
    logic [W:0]   cc;

    // operand steering for the shared adder
    always_comb begin
        op_x = '0;
        op_y = '0;
        unique case (fn)
            ALU_PASS_A: op_x = a;
            ALU_PASS_B: op_y = b;
            ALU_SUB:    begin op_x = a; op_y = ~b; end
            ALU_ADD:    begin op_x = a; op_y = b;  end
            default:    begin op_x = '0; op_y = '0; end
        endcase
    end

    assign cc[0] = cin;
    generate
        for (genvar gi = 0; gi < W; gi++) begin : g_ripple
            assign sum[gi]  = op_x[gi] ^ op_y[gi] ^ cc[gi];
            assign cc[gi+1] = (op_x[gi] & op_y[gi]) | (cc[gi] & (op_x[gi] ^ op_y[gi]));
        end
    endgenerate

    always_comb begin
        y    = sum;
        cout = cc[W];
        unique case (fn)
            ALU_PASS_A, ALU_PASS_B, ALU_SUB, ALU_ADD: begin
                y    = sum;
                cout = cc[W];
            end
            ALU_AND:  begin y = a & b; cout = 1'b0; end
            ALU_OR:   begin y = a | b; cout = 1'b0; end
            ALU_XOR:  begin y = a ^ b; cout = 1'b0; end
            ALU_ONES: begin y = '1;    cout = 1'b0; end
            default:  begin y = '0;    cout = 1'b0; end
        endcase
    end
endmodule

// File: rtl/acc_shift.sv
module acc_shift
    import acc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] y,
    input  logic         k,
    input  shift_fn_e    fn,
    output logic [W-1:0] q,
    output logic         kout
);
    always_comb begin
        q    = y;
        kout = k;
        unique case (fn)
            SH_PASS: begin q = y;                   kout = k;      end
            SH_SHL:  begin q = {y[W-2:0], 1'b0};    kout = y[W-1]; end
            SH_SHR:  begin q = {1'b0, y[W-1:1]};    kout = y[0];   end
            SH_RLC:  begin q = {y[W-2:0], k};       kout = y[W-1]; end
            SH_RRC:  begin q = {k, y[W-1:1]};       kout = y[0];   end
            SH_ROL:  begin q = {y[W-2:0], y[W-1]};  kout = k;      end
            SH_ROR:  begin q = {y[0], y[W-1:1]};    kout = k;      end
            SH_ASR:  begin q = {y[W-1], y[W-1:1]};  kout = y[0];   end
            default: begin q = y;                   kout = k;      end
        endcase
    end
endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
    import acc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ld_ir,
    input  logic            ld_a,
    input  logic            ld_b,
    input  logic            ld_res,
    input  logic [W-1:0]    data_in,
    output logic [OP_W-1:0] ir_q,
    output logic [W-1:0]    a_q,
    output logic [W-1:0]    b_q,
    output logic [W-1:0]    res_q,
    output logic            carry_q
);
    localparam int IRB = OP_W;

    logic      a_from_shift, cin_from_c, alu_k, sh_k, cin;
    alu_fn_e   alu_fn;
    shift_fn_e sh_fn;
    logic [W-1:0] alu_y, sh_q, a_next;

    acc_decode u_dec (
        .ir          (ir_q),
        .a_from_shift(a_from_shift),
        .alu_fn      (alu_fn),
        .sh_fn       (sh_fn),
        .cin_from_c  (cin_from_c)
    );

    assign cin = cin_from_c ? carry_q : 1'b0;

    acc_alu #(.W(W)) u_alu (
        .a   (a_q),
        .b   (b_q),
        .cin (cin),
        .fn  (alu_fn),
        .y   (alu_y),
        .cout(alu_k)
    );

    acc_shift #(.W(W)) u_sh (
        .y   (alu_y),
        .k   (alu_k),
        .fn  (sh_fn),
        .q   (sh_q),
        .kout(sh_k)
    );

    assign a_next = a_from_shift ? sh_q : data_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            ir_q    <= '0;
            a_q     <= '0;
            b_q     <= '0;
            res_q   <= '0;
            carry_q <= 1'b0;
        end else begin
            if (ld_ir)  ir_q  <= data_in[IRB-1:0];
            if (ld_a)   a_q   <= a_next;
            if (ld_b)   b_q   <= data_in;
            if (ld_res) res_q <= sh_q;
            // result capture has priority over the clear from a B load
            if (ld_res)    carry_q <= sh_k;
            else if (ld_b) carry_q <= 1'b0;
        end
    end

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (ir_q == '0 && a_q == '0 && b_q == '0 && res_q == '0 && !carry_q));

    assert_a_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !ld_a |=> $stable(a_q));

    assert_res_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !ld_res |=> $stable(res_q));

    assert_ir_load_R3: assert property (@(posedge clk) disable iff (rst)
        ld_ir |=> ir_q == $past(data_in[IRB-1:0]));

    assert_a_from_bus_R4: assert property (@(posedge clk) disable iff (rst)
        (ld_a && !ir_q[IRB-1]) |=> a_q == $past(data_in));

    assert_ones_R5: assert property (@(posedge clk) disable iff (rst)
        (ld_res && ir_q[6:4] == 3'b111 && ir_q[3:1] == 3'b000) |=> (res_q == '1 && !carry_q));

    assert_c_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (ld_b && !ld_res) |=> !carry_q);
endmodule

// File: tb/tb_acc_datapath.sv
`timescale 1ns/1ps
module tb_acc_datapath;
    logic       clk = 1'b0;
    logic       rst;
    logic       ld_ir, ld_a, ld_b, ld_res;
    logic [7:0] data_in;
    logic [7:0] ir_q, a_q, b_q, res_q;
    logic       carry_q;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    acc_datapath dut (
        .clk(clk), .rst(rst), .ld_ir(ld_ir), .ld_a(ld_a), .ld_b(ld_b), .ld_res(ld_res),
        .data_in(data_in), .ir_q(ir_q), .a_q(a_q), .b_q(b_q), .res_q(res_q), .carry_q(carry_q)
    );

    // {opcode, A, B, C before, expected RES, expected C}
    localparam logic [33:0] VEC [19] = '{
        {8'h30, 8'h12, 8'h34, 1'b0, 8'h46, 1'b0},
        {8'h31, 8'hFF, 8'h01, 1'b1, 8'h01, 1'b1},
        {8'h30, 8'h80, 8'h80, 1'b0, 8'h00, 1'b1},
        {8'h70, 8'h5A, 8'h33, 1'b0, 8'hFF, 1'b0},
        {8'h21, 8'h10, 8'h03, 1'b1, 8'h0D, 1'b1},
        {8'h40, 8'hF0, 8'h3C, 1'b0, 8'h30, 1'b0},
        {8'h50, 8'hF0, 8'h0F, 1'b0, 8'hFF, 1'b0},
        {8'h60, 8'hAA, 8'hFF, 1'b0, 8'h55, 1'b0},
        {8'h01, 8'h7F, 8'h00, 1'b1, 8'h80, 1'b0},
        {8'h10, 8'h00, 8'h42, 1'b0, 8'h42, 1'b0},
        {8'h12, 8'h00, 8'h81, 1'b0, 8'h02, 1'b1},
        {8'h14, 8'h00, 8'h81, 1'b0, 8'h40, 1'b1},
        {8'h36, 8'h80, 8'h80, 1'b0, 8'h01, 1'b0},
        {8'h38, 8'hFF, 8'h03, 1'b0, 8'h81, 1'b0},
        {8'h1A, 8'h00, 8'h81, 1'b0, 8'h03, 1'b0},
        {8'h1C, 8'h00, 8'h81, 1'b0, 8'hC0, 1'b0},
        {8'h1E, 8'h00, 8'h82, 1'b0, 8'hC1, 1'b0},
        {8'h30, 8'hFF, 8'h00, 1'b0, 8'hFF, 1'b0},
        {8'h30, 8'hFF, 8'h05, 1'b0, 8'h04, 1'b1}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic li, input logic la, input logic lb, input logic lr,
                         input logic [7:0] d);
        @(negedge clk);
        ld_ir = li; ld_a = la; ld_b = lb; ld_res = lr; data_in = d;
        @(negedge clk);
        ld_ir = 1'b0; ld_a = 1'b0; ld_b = 1'b0; ld_res = 1'b0;
    endtask

    initial begin : watchdog
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; ld_ir = 0; ld_a = 0; ld_b = 0; ld_res = 0; data_in = 8'hA5;
        repeat (3) @(negedge clk);
        // R1: reset state, including an active strobe ignored under reset
        ld_ir = 1'b1; ld_a = 1'b1;
        @(negedge clk);
        chk("R1 reset", {ir_q, a_q}, 16'h0000);
        chk("R1 reset", {b_q, res_q}, 16'h0000);
        chk("R1 reset carry", {15'd0, carry_q}, 16'd0);
        ld_ir = 1'b0; ld_a = 1'b0;
        rst = 1'b0;

        // vector table: R5 R6 R7 R9
        for (int i = 0; i < 19; i++) begin
            logic [7:0] op, av, bv, er;
            logic       cv, ec;
            {op, av, bv, cv, er, ec} = VEC[i];
            pulse(1, 0, 0, 0, 8'h00);
            pulse(0, 1, 0, 0, av);
            pulse(0, 0, 1, 0, bv);
            if (cv) begin
                pulse(1, 0, 0, 0, 8'h76);   // ones, rotate left through carry -> C=1
                pulse(0, 0, 0, 1, 8'h00);
            end
            pulse(1, 0, 0, 0, op);
            pulse(0, 0, 0, 1, 8'h00);
            chk("R5 R6 R7 R9 vector", {7'd0, res_q, carry_q}, {7'd0, er, ec});
        end

        // R2: no strobes, bus toggles -> all registers hold
        begin
            logic [7:0] hi, ha, hb, hr;
            logic       hc;
            hi = ir_q; ha = a_q; hb = b_q; hr = res_q; hc = carry_q;
            pulse(0, 0, 0, 0, 8'h5C);
            pulse(0, 0, 0, 0, 8'hC5);
            chk("R2 hold ir/a", {ir_q, a_q}, {hi, ha});
            chk("R2 hold b/res", {b_q, res_q}, {hb, hr});
            chk("R2 hold carry", {15'd0, carry_q}, {15'd0, hc});
        end

        // R3: opcode register field capture
        pulse(1, 0, 0, 0, 8'hB7);
        chk("R3 ir load", {8'd0, ir_q}, 16'h00B7);

        // R4: minus one into A via the shifter path, then decrement
        pulse(1, 0, 0, 0, 8'hF0);
        pulse(0, 1, 0, 0, 8'h33);
        chk("R4 A from shifter", {8'd0, a_q}, 16'h00FF);
        pulse(0, 0, 1, 0, 8'h00);
        pulse(1, 0, 0, 0, 8'h30);
        pulse(0, 0, 0, 1, 8'h00);
        chk("R5 decrement zero", {7'd0, res_q, carry_q}, {7'd0, 8'hFF, 1'b0});
        pulse(0, 1, 0, 0, 8'h29);
        chk("R4 A from bus", {8'd0, a_q}, 16'h0029);

        // R8: B load alone clears the carry
        pulse(0, 0, 1, 0, 8'h10);
        chk("R8 B clears carry", {15'd0, carry_q}, 16'd0);

        // R8 R10: B and RES together; A=0x80, B=0x80 before -> RES 0x00, C=1, B new
        pulse(0, 1, 0, 0, 8'h80);
        pulse(0, 0, 1, 0, 8'h80);
        pulse(0, 0, 1, 1, 8'h11);
        chk("R10 RES uses old B", {8'd0, res_q}, 16'h0000);
        chk("R8 carry-out wins", {15'd0, carry_q}, 16'd1);
        chk("R10 B takes new", {8'd0, b_q}, 16'h0011);

        // R11: accumulation 5 + 7 + 9 + 20
        pulse(1, 0, 0, 0, 8'h00);
        pulse(0, 1, 0, 0, 8'd5);
        pulse(0, 0, 1, 0, 8'd7);
        pulse(1, 0, 0, 0, 8'hB0);
        pulse(0, 1, 1, 0, 8'd9);
        chk("R11 sum 12", {8'd0, a_q}, 16'd12);
        pulse(0, 1, 1, 0, 8'd20);
        pulse(0, 1, 0, 0, 8'hEE);
        chk("R11 sum 41", {8'd0, a_q}, 16'd41);

        // R10: opcode and A together; old opcode 0xB0 feeds back A+B=41+20
        pulse(1, 1, 0, 0, 8'h00);
        chk("R10 A uses old opcode", {8'd0, a_q}, 16'd61);
        chk("R10 new opcode latched", {8'd0, ir_q}, 16'h0000);

        // R1: reset again from a loaded state
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R1 re-reset", {a_q, res_q}, 16'h0000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule